// File: doc/BRIEF.md
# Downstream Port Reset Chirp Controller

This block runs the speed negotiation of a high-speed hub's downstream port while that port holds the bus in reset. When a reset request arrives it drives SE0 for the whole reset period. During that period it listens to the decoded line state for a K chirp from the attached device. Once a K chirp has lasted long enough to count as valid and has then ended, the block waits a short gap. It then answers with an unbroken series of alternating K and J chirps and returns to SE0 until the period ends.

A port that sees no valid chirp, or one whose chirp is still on the line at the 7 ms mark, finishes a plain reset in full-speed mode. All timing counts a microsecond-scale tick input whose period is a parameter. One cycle after the reset period ends, the block pulses a done output, and the high-speed flag rises at that point if the reply was sent.

Top module: `hub_chirp_ctl`

## Requirements
- R1: After a request, exactly one of `se0_o`, `chirp_k_o`, `chirp_j_o` is high in each of the next RESET_T ticks, where RESET_T = RESET_US*1000/TICK_NS. Outside that window none of them is high.
- R2: The device chirp is accepted only after `line_i` has read K (code 2'b10) on KQUAL_T consecutive ticks, where KQUAL_T = ceil(KQUAL_NS/TICK_NS). A shorter run, or a run broken by any other code, is not accepted.
- R3: If no device chirp is accepted, no chirp is driven, SE0 is held for the full period, and `hs_mode_o` stays low.
- R4: After an accepted device chirp, the first line-state sample that is not K marks its end. The reply starts GAP_T ticks after the cycle of that sample.
- R5: The reply is 2*PAIRS chirps with no gap between them. It starts with K and alternates K and J, and each chirp lasts CHIRP_T ticks.
- R6: After the last reply chirp, SE0 is driven until the reset period ends.
- R7: If K is still sampled on the tick that completes KMAX_T = KMAX_US*1000/TICK_NS ticks, the block falls back to full speed. A K that starts after that point is ignored.
- R8: `done_o` is high for exactly one cycle, the cycle after the last tick of the period. `hs_mode_o` rises in that same cycle when the reply completed, and it holds until the next request.
- R9: A request while a reset is running restarts the period from zero, stops any chirp, and clears `hs_mode_o`.
- R10: In and after reset, and while no request has been made, all drive outputs and `done_o` are low whatever `line_i` and `tick_i` show.
- R11: State advances only on ticks. With no tick, no request and no done pulse, the outputs hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Reset request, one-cycle pulse |
| line_i | input | 2 | Decoded line state: 2'b00 SE0, 2'b01 J, 2'b10 K, 2'b11 treated as not K |
| tick_i | input | 1 | Time-base tick, one per TICK_NS nanoseconds |
| se0_o | output | 1 | Drive SE0 on the port |
| chirp_k_o | output | 1 | Drive a K chirp |
| chirp_j_o | output | 1 | Drive a J chirp |
| hs_mode_o | output | 1 | Port finished the reset in high-speed mode |
| done_o | output | 1 | One-cycle pulse after the reset period ends |

## Verification
The hardest situation to reach from the ports is the tie at the 7 ms mark. A device chirp that ends on the last sample before the limit must still earn a reply, and one that is sampled on the limiting tick itself must not. The bench scales all time parameters down and ticks every cycle, so the device K can be placed to the exact cycle on either side of that limit. A second tie puts a run one tick short of acceptance right next to a run that just reaches it.

// File: rtl/hcc_pkg.sv
package hcc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LISTEN,
    ST_DEVK,
    ST_REPLY,
    ST_HSTAIL,
    ST_FSTAIL,
    ST_FIN
  } hcc_state_e;

  localparam logic [1:0] LINE_K = 2'b10;

endpackage

// File: rtl/hcc_period_timer.sv
module hcc_period_timer #(
  parameter int unsigned END_T  = 21000,
  parameter int unsigned MARK_T = 14000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic at_end,
  output logic at_mark
);

  localparam int unsigned W = $clog2(END_T + 1);
  localparam logic [W-1:0] END_M1  = W'(END_T - 1);
  localparam logic [W-1:0] MARK_M1 = W'(MARK_T - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | (run & tick);
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_end  = run & tick & (cnt_q == END_M1);
  assign at_mark = run & tick & (cnt_q == MARK_M1);

endmodule

// File: rtl/hcc_k_qual.sv
module hcc_k_qual #(
  parameter int unsigned QUAL_T = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic is_k,
  input  logic tick,
  output logic valid
);

  generate
    if (QUAL_T <= 1) begin : g_direct
      assign valid = en & is_k & tick;
    end else begin : g_count
      localparam int unsigned QW = $clog2(QUAL_T);
      localparam logic [QW-1:0] LAST = QW'(QUAL_T - 1);

      logic [QW-1:0] run_q, run_d;
      logic          run_en;

      always_comb begin
        run_en = ~en | ~is_k | tick;
        if (!en || !is_k)       run_d = '0;
        else if (run_q != LAST) run_d = run_q + 1'b1;
        else                    run_d = run_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (run_en) run_q <= run_d;
      end

      assign valid = en & is_k & tick & (run_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/hcc_chirp_seq.sv
module hcc_chirp_seq #(
  parameter int unsigned CHIRP_T = 100,
  parameter int unsigned GAP_T   = 40,
  parameter int unsigned NCHIRP  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic go,
  input  logic tick,
  output logic chirp_k,
  output logic chirp_j,
  output logic fin
);

  localparam int unsigned MAXP = (CHIRP_T > GAP_T) ? CHIRP_T : GAP_T;
  localparam int unsigned PW   = $clog2(MAXP + 1);
  localparam int unsigned IW   = $clog2(NCHIRP + 1);
  localparam logic [PW-1:0] GAP_M1   = PW'(GAP_T - 1);
  localparam logic [PW-1:0] CHIRP_M1 = PW'(CHIRP_T - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(NCHIRP - 1);

  logic          act_q, act_d;
  logic          gap_q, gap_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          step, ph_last, idx_last, upd;

  always_comb begin
    step     = act_q & tick;
    ph_last  = gap_q ? (ph_q == GAP_M1) : (ph_q == CHIRP_M1);
    idx_last = (idx_q == IDX_LAST);
    upd      = clr | go | step;
    act_d    = act_q;
    gap_d    = gap_q;
    ph_d     = ph_q;
    idx_d    = idx_q;
    if (clr) begin
      act_d = 1'b0;
      gap_d = 1'b0;
      ph_d  = '0;
      idx_d = '0;
    end else if (go) begin
      act_d = 1'b1;
      gap_d = 1'b1;
      ph_d  = '0;
      idx_d = '0;
    end else if (step) begin
      if (ph_last) begin
        ph_d = '0;
        if (gap_q)         gap_d = 1'b0;
        else if (idx_last) act_d = 1'b0;
        else               idx_d = idx_q + 1'b1;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      gap_q <= 1'b0;
      ph_q  <= '0;
      idx_q <= '0;
    end else if (upd) begin
      act_q <= act_d;
      gap_q <= gap_d;
      ph_q  <= ph_d;
      idx_q <= idx_d;
    end
  end

  assign chirp_k = act_q & ~gap_q & ~idx_q[0];
  assign chirp_j = act_q & ~gap_q &  idx_q[0];
  assign fin     = step & ~gap_q & ph_last & idx_last;

endmodule

// File: rtl/hub_chirp_ctl.sv
module hub_chirp_ctl
  import hcc_pkg::*;
#(
  parameter int unsigned TICK_NS  = 500,
  parameter int unsigned RESET_US = 10500,
  parameter int unsigned KQUAL_NS = 2500,
  parameter int unsigned CHIRP_US = 50,
  parameter int unsigned GAP_US   = 20,
  parameter int unsigned KMAX_US  = 7000,
  parameter int unsigned PAIRS    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] line_i,
  input  logic       tick_i,
  output logic       se0_o,
  output logic       chirp_k_o,
  output logic       chirp_j_o,
  output logic       hs_mode_o,
  output logic       done_o
);

  localparam int unsigned RESET_T = RESET_US * 1000 / TICK_NS;
  localparam int unsigned KQUAL_T = (KQUAL_NS + TICK_NS - 1) / TICK_NS;
  localparam int unsigned CHIRP_T = CHIRP_US * 1000 / TICK_NS;
  localparam int unsigned GAP_T   = GAP_US * 1000 / TICK_NS;
  localparam int unsigned KMAX_T  = KMAX_US * 1000 / TICK_NS;
  localparam int unsigned NCHIRP  = 2 * PAIRS;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  hcc_state_e state_q, state_d;
  logic       hs_q, hs_d, hs_en;
  logic       busy, is_k;
  logic       rt_end, rt_mark;
  logic       kq_en, kq_valid;
  logic       seq_go, seq_clr, seq_k, seq_j, seq_fin;

  assign is_k = (line_i == LINE_K);
  assign busy = state_q inside {ST_LISTEN, ST_DEVK, ST_REPLY, ST_HSTAIL, ST_FSTAIL};

  hcc_period_timer #(
    .END_T  (RESET_T),
    .MARK_T (KMAX_T)
  ) i_timer (
    .clk     (clk),
    .rst_n   (rst_sn),
    .clr     (start_i),
    .run     (busy),
    .tick    (tick_i),
    .at_end  (rt_end),
    .at_mark (rt_mark)
  );

  assign kq_en = (state_q == ST_LISTEN) & ~start_i;

  hcc_k_qual #(
    .QUAL_T (KQUAL_T)
  ) i_kqual (
    .clk   (clk),
    .rst_n (rst_sn),
    .en    (kq_en),
    .is_k  (is_k),
    .tick  (tick_i),
    .valid (kq_valid)
  );

  assign seq_clr = start_i | (state_q == ST_FIN);

  hcc_chirp_seq #(
    .CHIRP_T (CHIRP_T),
    .GAP_T   (GAP_T),
    .NCHIRP  (NCHIRP)
  ) i_seq (
    .clk     (clk),
    .rst_n   (rst_sn),
    .clr     (seq_clr),
    .go      (seq_go),
    .tick    (tick_i),
    .chirp_k (seq_k),
    .chirp_j (seq_j),
    .fin     (seq_fin)
  );

  // next state
  always_comb begin
    state_d = state_q;
    seq_go  = 1'b0;
    if (start_i) begin
      state_d = ST_LISTEN;
    end else begin
      case (state_q)
        ST_IDLE: state_d = ST_IDLE;
        ST_FIN:  state_d = ST_IDLE;
        default: begin
          if (rt_end) begin
            state_d = ST_FIN;
          end else begin
            case (state_q)
              ST_LISTEN: begin
                if (rt_mark)       state_d = ST_FSTAIL;
                else if (kq_valid) state_d = ST_DEVK;
              end
              ST_DEVK: begin
                if (!is_k) begin
                  state_d = ST_REPLY;
                  seq_go  = 1'b1;
                end else if (rt_mark) begin
                  state_d = ST_FSTAIL;
                end
              end
              ST_REPLY: begin
                if (seq_fin) state_d = ST_HSTAIL;
              end
              default: state_d = state_q;
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    hs_en = start_i | ((state_q == ST_HSTAIL) & rt_end);
    hs_d  = ~start_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    hs_q <= 1'b0;
    else if (hs_en) hs_q <= hs_d;
  end

  assign chirp_k_o = (state_q == ST_REPLY) & seq_k;
  assign chirp_j_o = (state_q == ST_REPLY) & seq_j;
  assign se0_o     = busy & ~(chirp_k_o | chirp_j_o);
  assign done_o    = (state_q == ST_FIN);
  assign hs_mode_o = hs_q;

endmodule

// File: rtl/hcc_chk.sv
module hcc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [1:0] line_i,
  input logic       tick_i,
  input logic       se0_o,
  input logic       chirp_k_o,
  input logic       chirp_j_o,
  input logic       hs_mode_o,
  input logic       done_o
);

  logic seen_k_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             seen_k_q <= 1'b0;
    else if (start_i)                       seen_k_q <= 1'b0;
    else if (tick_i && line_i == 2'b10)     seen_k_q <= 1'b1;
  end

  assert_single_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({se0_o, chirp_k_o, chirp_j_o}));

  assert_chirp_needs_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chirp_k_o || chirp_j_o) |-> seen_k_q);

  assert_j_follows_k_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chirp_j_o) |-> $past(chirp_k_o));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_hs_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode_o) |-> done_o);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(se0_o || chirp_k_o || chirp_j_o));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (se0_o && !hs_mode_o && !done_o));

  assert_tick_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !start_i && !done_o) |=>
      $stable({se0_o, chirp_k_o, chirp_j_o, hs_mode_o}));

endmodule

bind hub_chirp_ctl hcc_chk i_hcc_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .start_i   (start_i),
  .line_i    (line_i),
  .tick_i    (tick_i),
  .se0_o     (se0_o),
  .chirp_k_o (chirp_k_o),
  .chirp_j_o (chirp_j_o),
  .hs_mode_o (hs_mode_o),
  .done_o    (done_o)
);

// File: tb/test_hub_chirp_ctl.sv
module test_hub_chirp_ctl;

  localparam int TICK_NS  = 500;
  localparam int RESET_US = 400;
  localparam int KQUAL_NS = 2500;
  localparam int CHIRP_US = 10;
  localparam int GAP_US   = 5;
  localparam int KMAX_US  = 100;
  localparam int PAIRS    = 3;

  localparam int RT = RESET_US * 1000 / TICK_NS;   // 800 ticks
  localparam int CT = CHIRP_US * 1000 / TICK_NS;   // 20 ticks

  localparam logic [1:0] L_SE0 = 2'b00;
  localparam logic [1:0] L_J   = 2'b01;
  localparam logic [1:0] L_K   = 2'b10;

  typedef struct packed {
    int ks1;
    int kl1;
    int ks2;
    int kl2;
    int hs;
    int first;
  } vec_t;

  // device K segments (cycle offsets from request), expected mode, first chirp cycle
  localparam vec_t VECS [10] = '{
    '{10,  40,  0, 0, 1, 61},
    '{3,   5,   0, 0, 1, 19},
    '{3,   4,   0, 0, 0, 0},
    '{150, 49,  0, 0, 1, 210},
    '{150, 50,  0, 0, 0, 0},
    '{0,   0,   0, 0, 0, 0},
    '{250, 30,  0, 0, 0, 0},
    '{5,   4,  10, 4, 0, 0},
    '{5,   4,  10, 5, 1, 26},
    '{0,   195, 0, 0, 1, 206}
  };

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [1:0] line_i;
  logic       tick_i;
  logic       se0_o, chirp_k_o, chirp_j_o, hs_mode_o, done_o;

  int checks;
  int fails;

  int r_busy, r_multi, r_kc, r_jc, r_first, r_done_n, r_done_cyc, r_hs_early;
  bit r_first_k, r_hs0, r_hs_done, r_hs_after, r_se0_end;

  hub_chirp_ctl #(
    .TICK_NS  (TICK_NS),
    .RESET_US (RESET_US),
    .KQUAL_NS (KQUAL_NS),
    .CHIRP_US (CHIRP_US),
    .GAP_US   (GAP_US),
    .KMAX_US  (KMAX_US),
    .PAIRS    (PAIRS)
  ) i_hub_chirp_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .line_i    (line_i),
    .tick_i    (tick_i),
    .se0_o     (se0_o),
    .chirp_k_o (chirp_k_o),
    .chirp_j_o (chirp_j_o),
    .hs_mode_o (hs_mode_o),
    .done_o    (done_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic clear_results();
    r_busy = 0; r_multi = 0; r_kc = 0; r_jc = 0; r_first = -1;
    r_done_n = 0; r_done_cyc = -1; r_hs_early = 0;
    r_first_k = 1'b0; r_hs0 = 1'b1; r_hs_done = 1'b0; r_hs_after = 1'b0; r_se0_end = 1'b0;
  endtask

  task automatic do_reset(input int ks1, input int kl1, input int ks2, input int kl2,
                          input int tdiv, input int restart_at);
    int base;
    bit quiet;
    base  = 0;
    quiet = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    line_i  = L_SE0;
    tick_i  = (tdiv == 1);
    clear_results();
    for (int c = 0; c < 4000; c++) begin
      int cc;
      int nd;
      @(negedge clk);
      start_i = 1'b0;
      cc = c - base;
      nd = int'(se0_o) + int'(chirp_k_o) + int'(chirp_j_o);
      if (nd > 1) r_multi++;
      if (nd > 0) r_busy++;
      if (chirp_k_o) r_kc++;
      if (chirp_j_o) r_jc++;
      if ((chirp_k_o || chirp_j_o) && r_first < 0) begin
        r_first   = cc;
        r_first_k = chirp_k_o;
      end
      if (cc == 0) r_hs0 = hs_mode_o;
      if (cc == RT - 1) r_se0_end = se0_o;
      if (nd > 0 && hs_mode_o) r_hs_early++;
      if (done_o) begin
        r_done_n++;
        if (r_done_cyc < 0) r_done_cyc = cc;
        r_hs_done = hs_mode_o;
      end
      if (r_done_cyc >= 0 && cc == r_done_cyc + 2) begin
        r_hs_after = hs_mode_o;
        break;
      end
      if (restart_at >= 0 && c == restart_at) begin
        start_i = 1'b1;
        line_i  = L_SE0;
        tick_i  = 1'b1;
        clear_results();
        base  = c + 1;
        quiet = 1'b1;
      end else begin
        line_i = (!quiet && ((cc >= ks1 && cc < ks1 + kl1) || (cc >= ks2 && cc < ks2 + kl2)))
                 ? L_K : L_SE0;
        tick_i = (tdiv == 1) ? 1'b1 : cc[0];
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 act=%0d exp=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks  = 0;
    fails   = 0;
    rst_n   = 1'b0;
    start_i = 1'b0;
    line_i  = L_SE0;
    tick_i  = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset
    chk(!(se0_o || chirp_k_o || chirp_j_o || hs_mode_o || done_o), "R10 outputs in reset",
        int'({se0_o, chirp_k_o, chirp_j_o, hs_mode_o, done_o}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10: no request, K on the line with ticks: nothing driven
    begin
      int act;
      act = 0;
      line_i = L_K;
      tick_i = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (se0_o || chirp_k_o || chirp_j_o || done_o || hs_mode_o) act++;
      end
      chk(act == 0, "R10 idle ignores line and tick", act, 0);
      line_i = L_J;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (se0_o || chirp_k_o || chirp_j_o || done_o) act++;
      end
      chk(act == 0, "R10 idle ignores J", act, 0);
      line_i = L_SE0;
    end

    // table of stimulus and expected results
    for (int v = 0; v < 10; v++) begin
      do_reset(VECS[v].ks1, VECS[v].kl1, VECS[v].ks2, VECS[v].kl2, 1, -1);
      chk(r_busy == RT, $sformatf("R1 reset length v%0d", v), r_busy, RT);
      chk(r_multi == 0, $sformatf("R1 single drive v%0d", v), r_multi, 0);
      chk(r_done_n == 1 && r_done_cyc == RT, $sformatf("R8 done cycle v%0d", v), r_done_cyc, RT);
      chk(int'(r_hs_done) == VECS[v].hs, $sformatf("R8 mode at done v%0d", v),
          int'(r_hs_done), VECS[v].hs);
      chk(int'(r_hs_after) == VECS[v].hs, $sformatf("R8 mode held v%0d", v),
          int'(r_hs_after), VECS[v].hs);
      chk(r_hs_early == 0, $sformatf("R8 mode low while driving v%0d", v), r_hs_early, 0);
      chk(r_hs0 == 1'b0, $sformatf("R9 mode cleared at request v%0d", v), int'(r_hs0), 0);
      chk(r_se0_end == 1'b1, $sformatf("R6 SE0 at period end v%0d", v), int'(r_se0_end), 1);
      if (VECS[v].hs != 0) begin
        chk(r_first == VECS[v].first, $sformatf("R4 reply start v%0d", v), r_first, VECS[v].first);
        chk(r_first_k == 1'b1, $sformatf("R5 reply opens with K v%0d", v), int'(r_first_k), 1);
        chk(r_kc == PAIRS * CT, $sformatf("R5 K chirp cycles v%0d", v), r_kc, PAIRS * CT);
        chk(r_jc == PAIRS * CT, $sformatf("R5 J chirp cycles v%0d", v), r_jc, PAIRS * CT);
      end else begin
        chk(r_kc + r_jc == 0, $sformatf("R3 R2 R7 no reply v%0d", v), r_kc + r_jc, 0);
      end
    end

    // R11: tick every other cycle doubles every duration
    do_reset(10, 40, 0, 0, 2, -1);
    chk(r_busy == 2 * RT, "R11 reset length slow tick", r_busy, 2 * RT);
    chk(r_kc == 2 * PAIRS * CT, "R11 K chirp cycles slow tick", r_kc, 2 * PAIRS * CT);
    chk(r_jc == 2 * PAIRS * CT, "R11 J chirp cycles slow tick", r_jc, 2 * PAIRS * CT);
    chk(r_hs_done == 1'b1, "R11 mode slow tick", int'(r_hs_done), 1);

    // R9: request during the reply restarts the period, no K afterwards
    do_reset(10, 40, 0, 0, 1, 100);
    chk(r_busy == RT, "R9 restarted period length", r_busy, RT);
    chk(r_kc + r_jc == 0, "R9 chirps stopped by restart", r_kc + r_jc, 0);
    chk(r_done_n == 1 && r_done_cyc == RT, "R9 done after restart", r_done_cyc, RT);
    chk(r_hs_done == 1'b0, "R9 full speed after restart", int'(r_hs_done), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule